// File: doc/BRIEF.md
# Cartridge Bank Controller with Nibble RAM

This block sits between a CPU with a 16-bit address bus and 8-bit data bus and a cartridge ROM. In the lower half of the CPU address space (0x0000–0x7FFF) it turns each read into an 18-bit physical ROM address. The first 16 KiB of that window is fixed. The second 16 KiB shows one of sixteen ROM banks, chosen by a 4-bit bank register. A small boot image covers the lowest 256 bytes after reset. The first read into 0x0100–0x0FFF hands that area back to the cartridge for good. The ROM and the boot image are outside the block: it drives their addresses and picks between the two returned bytes.

Writes into 0x0000–0x3FFF do not reach ROM. They load two control registers instead: an enable flag for the on-board RAM and the bank number. CPU address bit 4 decides whether such a write lands or is dropped. The RAM is held inside the block as 512 entries of 4 bits. It sits in the window 0xA000–0xBFFF and repeats every 512 bytes across it. While the enable flag is clear it reads as zero and ignores writes.

All read data is combinational from the current address. Register and RAM updates take effect at the clock edge that ends the access. A read strobe and a write strobe may be raised in the same cycle; both act on the one address.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A read at 0x0000–0x3FFF that is not taken by the boot overlay drives rom_addr = {4'b0000, cpu_addr[13:0]} and returns rom_rdata, whatever the bank register holds.
- R2: While the boot overlay is active, a read at 0x0000–0x00FF drives boot_addr = cpu_addr[7:0] and returns boot_rdata in place of cartridge ROM data.
- R3: A read strobe at 0x0100–0x0FFF while the overlay is active turns the overlay off at that clock edge. That read, and every later read below 0x0100, returns rom_rdata. Reads at any other address leave the overlay as it is.
- R4: A read at 0x4000–0x7FFF drives rom_addr = {bank, cpu_addr[13:0]}, an 18-bit address with the 4-bit bank on bits 17:14. Bank 0 is used as is and is not remapped.
- R5: A write at 0x0000–0x1FFF with cpu_addr[4] = 0 sets the RAM enable exactly when cpu_wdata[3:0] = 4'hA. Any other low nibble clears it, whatever bits 7:4 hold.
- R6: A write at 0x2000–0x3FFF with cpu_addr[4] = 1 loads cpu_wdata[3:0] into the bank register. Bits 7:4 are ignored.
- R7: A write at 0x0000–0x1FFF with cpu_addr[4] = 1 has no effect. So does a write at 0x2000–0x3FFF with cpu_addr[4] = 0, and so does any write at 0x4000–0x7FFF.
- R8: The RAM window is 0xA000–0xBFFF, and only cpu_addr[8:0] picks the entry. Addresses that differ only in bits 12:9 reach the same entry.
- R9: A RAM read with RAM enabled returns {4'b0000, stored nibble}. With RAM disabled it returns 0x00 and RAM writes are dropped. Reads at addresses in neither the ROM window nor the RAM window return 0x00.
- R10: A RAM write stores cpu_wdata[3:0] only.
- R11: Reset clears the RAM enable, sets the bank register to 1 and turns the boot overlay on. It does not alter the RAM contents.
- R12: When the read and write strobes are both high in one cycle, cpu_rdata shows the state before that clock edge, and both the read side effect and the write take effect at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current address |
| rom_addr | output | 18 | Physical cartridge ROM address |
| rom_rdata | input | 8 | Byte returned by the cartridge ROM |
| boot_addr | output | 8 | Boot image address |
| boot_rdata | input | 8 | Byte returned by the boot image |

## Verification
Two functions can coincide in one cycle:
- **Overlay release and enable write.** A single access at 0x0100 with both strobes high and data 0x0A is both the read that ends the boot overlay and a write to the enable register, since address bit 4 is clear. The bench issues this access right after a reset. It expects that cycle's data to come from cartridge ROM, a later read at 0x0000 to come from ROM as well, and the RAM to be readable afterwards with the contents it held before the reset.
- **RAM read and write of one entry.** A RAM read and write of the same entry in one cycle must show the old nibble in that cycle and the new one on the next read.

Both cases are judged against a model the bench keeps of the RAM and of the two ROM data sources.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int CPU_AW     = 16;
    localparam int SEL_BIT    = 4;
    localparam logic [2:0] CTRL_EN_TAG   = 3'b000;
    localparam logic [2:0] CTRL_BANK_TAG = 3'b001;
    localparam logic [2:0] RAM_WIN_TAG   = 3'b101;

    typedef enum logic [1:0] {
        WIN_ROM_LO,
        WIN_ROM_HI,
        WIN_RAM,
        WIN_NONE
    } win_e;

    typedef enum logic [1:0] {
        WT_ENABLE,
        WT_BANK,
        WT_NONE
    } wtgt_e;

    function automatic win_e decode_window(input logic [CPU_AW-1:0] a);
        if (a[CPU_AW-1] == 1'b0)
            return a[CPU_AW-2] ? WIN_ROM_HI : WIN_ROM_LO;
        if (a[CPU_AW-1 -: 3] == RAM_WIN_TAG)
            return WIN_RAM;
        return WIN_NONE;
    endfunction

    function automatic wtgt_e write_target(input logic [CPU_AW-1:0] a);
        if (a[CPU_AW-1 -: 3] == CTRL_EN_TAG)
            return a[SEL_BIT] ? WT_NONE : WT_ENABLE;
        if (a[CPU_AW-1 -: 3] == CTRL_BANK_TAG)
            return a[SEL_BIT] ? WT_BANK : WT_NONE;
        return WT_NONE;
    endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int BANK_W     = 4,
    parameter int KEY_W      = 4,
    parameter int ENABLE_KEY = 10,
    parameter int RESET_BANK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic              ram_en,
    output logic [BANK_W-1:0] bank
);
    import cbc_pkg::*;

    localparam logic [DW-1:0] KEY_MASK  = DW'((1 << KEY_W) - 1);
    localparam logic [DW-1:0] KEY_VALUE = DW'(ENABLE_KEY);
    localparam logic [DW-1:0] BANK_MASK = DW'((1 << BANK_W) - 1);

    typedef struct packed {
        logic              ram_en;
        logic [BANK_W-1:0] bank;
    } ctrl_t;

    ctrl_t st_d, st_q;
    wtgt_e tgt;

    always_comb begin
        st_d = st_q;
        tgt  = write_target(addr);
        if (wr) begin
            case (tgt)
                WT_ENABLE: st_d.ram_en = ((wdata & KEY_MASK) == KEY_VALUE);
                WT_BANK:   st_d.bank   = BANK_W'(wdata & BANK_MASK);
                default:   st_d        = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ram_en <= 1'b0;
            st_q.bank   <= BANK_W'(RESET_BANK);
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_en = st_q.ram_en;
    assign bank   = st_q.bank;

    // R7: the bank changes only after a write that the decode steers to it
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && tgt == WT_BANK) |=> $stable(st_q.bank));

    // R7: the enable changes only after a write that the decode steers to it
    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && tgt == WT_ENABLE) |=> $stable(st_q.ram_en));

    // R6: a steered bank write lands with its low bits
    p_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == WT_BANK) |=> (st_q.bank == BANK_W'($past(wdata))));

    // R5: the key nibble always leaves RAM enabled
    p_en_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == WT_ENABLE && wdata[KEY_W-1:0] == KEY_W'(ENABLE_KEY)) |=> st_q.ram_en);

endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map #(
    parameter int AW          = 16,
    parameter int BANK_W      = 4,
    parameter int OFS_W       = 14,
    parameter int BOOT_AW     = 8,
    parameter int CLEAR_LIMIT = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd,
    input  logic [AW-1:0]           addr,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    output logic [BOOT_AW-1:0]      boot_addr,
    output logic                    boot_sel
);
    localparam logic [AW-1:0] BOOT_SPAN = AW'(1 << BOOT_AW);
    localparam logic [AW-1:0] CLR_END   = AW'(CLEAR_LIMIT);

    typedef struct packed {
        logic boot_on;
    } map_t;

    map_t st_d, st_q;
    logic in_clear_zone;
    logic hi_half;

    always_comb begin
        in_clear_zone = (addr >= BOOT_SPAN) && (addr < CLR_END);
        hi_half       = addr[OFS_W];
        st_d          = st_q;
        if (rd && st_q.boot_on && in_clear_zone)
            st_d.boot_on = 1'b0;
        boot_sel  = st_q.boot_on && (addr < BOOT_SPAN);
        boot_addr = addr[BOOT_AW-1:0];
        rom_addr  = {(hi_half ? bank : {BANK_W{1'b0}}), addr[OFS_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.boot_on <= 1'b1;
        else
            st_q <= st_d;
    end

    // R3: once released the overlay never returns without reset
    p_boot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.boot_on |=> !st_q.boot_on);

    // R3: a read in the release zone ends the overlay
    p_boot_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr >= BOOT_SPAN) && (addr < CLR_END)) |=> !st_q.boot_on);

    // R3: outside the release zone the overlay keeps its state
    p_boot_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && (addr >= BOOT_SPAN) && (addr < CLR_END)) |=> $stable(st_q.boot_on));

endmodule

// File: rtl/cbc_nibble_ram.sv
module cbc_nibble_ram #(
    parameter int DEPTH = 512,
    parameter int NW    = 4,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     wr,
    input  logic                     ram_en,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    localparam int RAM_AW = $clog2(DEPTH);

    typedef struct packed {
        logic              we;
        logic [RAM_AW-1:0] idx;
        logic [NW-1:0]     nib;
    } wreq_t;

    logic [NW-1:0] mem_q [DEPTH];
    wreq_t req_d;

    always_comb begin
        req_d.we  = sel && wr && ram_en;
        req_d.idx = idx;
        req_d.nib = NW'(wdata);
        rdata     = (sel && ram_en) ? DW'(mem_q[idx]) : '0;
    end

    always_ff @(posedge clk) begin
        if (req_d.we)
            mem_q[req_d.idx] <= req_d.nib;
    end

    // R9: a disabled RAM never shows data
    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (rdata == '0));

    // R9: the upper bits of a RAM byte are always zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NW] == '0);

    // R10: an enabled write is readable with its low nibble on the next cycle at the same index
    p_nib_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && ram_en) ##1 (sel && ram_en && idx == $past(idx))
        |-> rdata == DW'($past(wdata[NW-1:0])));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int BANK_W    = 4,
    parameter int OFS_W     = 14,
    parameter int BOOT_AW   = 8,
    parameter int RAM_DEPTH = 512,
    parameter int RAM_NW    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           cpu_addr,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [DW-1:0]           cpu_wdata,
    output logic [DW-1:0]           cpu_rdata,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    input  logic [DW-1:0]           rom_rdata,
    output logic [BOOT_AW-1:0]      boot_addr,
    input  logic [DW-1:0]           boot_rdata
);
    import cbc_pkg::*;

    localparam int RAM_AW = $clog2(RAM_DEPTH);

    logic              ram_en;
    logic [BANK_W-1:0] bank;
    logic              boot_sel;
    logic [DW-1:0]     ram_rdata;
    win_e              win;

    cbc_ctrl_regs #(.AW(AW), .DW(DW), .BANK_W(BANK_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .ram_en (ram_en),
        .bank   (bank)
    );

    cbc_rom_map #(.AW(AW), .BANK_W(BANK_W), .OFS_W(OFS_W), .BOOT_AW(BOOT_AW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (cpu_rd),
        .addr      (cpu_addr),
        .bank      (bank),
        .rom_addr  (rom_addr),
        .boot_addr (boot_addr),
        .boot_sel  (boot_sel)
    );

    cbc_nibble_ram #(.DEPTH(RAM_DEPTH), .NW(RAM_NW), .DW(DW)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (win == WIN_RAM),
        .wr     (cpu_wr),
        .ram_en (ram_en),
        .idx    (cpu_addr[RAM_AW-1:0]),
        .wdata  (cpu_wdata),
        .rdata  (ram_rdata)
    );

    always_comb begin
        win = decode_window(cpu_addr);
        case (win)
            WIN_ROM_LO: cpu_rdata = boot_sel ? boot_rdata : rom_rdata;
            WIN_ROM_HI: cpu_rdata = rom_rdata;
            WIN_RAM:    cpu_rdata = ram_rdata;
            default:    cpu_rdata = '0;
        endcase
    end

    // R4: an upper-half read carries the live bank on the top address bits
    p_hi_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_ROM_HI) |-> (rom_addr[BANK_W+OFS_W-1:OFS_W] == bank));

    // R1: a lower-half read never carries bank bits
    p_lo_flat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_ROM_LO) |-> (rom_addr[BANK_W+OFS_W-1:OFS_W] == '0));

    // R2: the boot image is only selected below its span
    p_boot_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> (cpu_addr < AW'(1 << BOOT_AW)));

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [17:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [7:0]  boot_addr;
    logic [7:0]  boot_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  got_rdata;
    logic [17:0] got_rom;
    logic [7:0]  got_boot;
    logic [3:0]  mdl [512];

    always #4 clk = ~clk;

    function automatic logic [7:0] rom_model(input logic [17:0] a);
        return a[7:0] ^ {a[17:14], a[11:8]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] boot_model(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    function automatic logic [3:0] nib(input int i);
        logic [8:0] v;
        v = 9'(i);
        return v[3:0] ^ v[7:4] ^ {v[8], 3'b000};
    endfunction

    assign rom_rdata  = rom_model(rom_addr);
    assign boot_rdata = boot_model(boot_addr);

    cart_bank_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .rom_addr   (rom_addr),
        .rom_rdata  (rom_rdata),
        .boot_addr  (boot_addr),
        .boot_rdata (boot_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd    = rd;
        cpu_wr    = wr;
        cpu_addr  = a;
        cpu_wdata = d;
        #2;
        got_rdata = cpu_rdata;
        got_rom   = rom_addr;
        got_boot  = boot_addr;
        @(posedge clk);
        #1;
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic rd_op(input logic [15:0] a);
        op(1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic wr_op(input logic [15:0] a, input logic [7:0] d);
        op(1'b0, 1'b1, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();

        // R11: reset state
        rd_op(16'h4000);
        check("R11 reset bank is 1", 32'(got_rom), 32'h04000);
        rd_op(16'hA123);
        check("R11 reset RAM disabled", 32'(got_rdata), 32'h00);
        rd_op(16'h0005);
        check("R11 reset overlay on", 32'(got_rdata), 32'(boot_model(8'h05)));

        // R2: whole boot span while overlay active
        for (int i = 0; i < 256; i++) begin
            rd_op(16'(i));
            check("R2 boot data", 32'(got_rdata), 32'(boot_model(8'(i))));
            check("R2 boot addr", 32'(got_boot), 32'(i));
        end

        // R3: read outside release zone keeps overlay
        rd_op(16'h1000);
        check("R3 read 0x1000 from ROM", 32'(got_rdata), 32'(rom_model(18'h01000)));
        rd_op(16'h3FFF);
        check("R1 read 0x3FFF from ROM", 32'(got_rdata), 32'(rom_model(18'h03FFF)));
        rd_op(16'h0040);
        check("R3 overlay kept", 32'(got_rdata), 32'(boot_model(8'h40)));

        // R3: releasing read
        rd_op(16'h0100);
        check("R3 release read from ROM", 32'(got_rdata), 32'(rom_model(18'h00100)));
        rd_op(16'h0000);
        check("R3 after release 0x0000", 32'(got_rdata), 32'(rom_model(18'h00000)));
        rd_op(16'h00FF);
        check("R3 after release 0x00FF", 32'(got_rdata), 32'(rom_model(18'h000FF)));

        // R1: lower half flat mapping
        for (int i = 0; i < 16384; i += 257) begin
            rd_op(16'(i));
            check("R1 lower rom_addr", 32'(got_rom), 32'(i));
            check("R1 lower data", 32'(got_rdata), 32'(rom_model(18'(i))));
        end

        // R6 and R4: every bank
        for (int b = 0; b < 16; b++) begin
            wr_op(16'h2010 + 16'(b * 256), 8'hF0 | 8'(b));
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a;
                a = (k == 0) ? 16'h4000 : (k == 1) ? 16'h4000 + 16'(b * 1021) : 16'h7FFF;
                rd_op(a);
                check("R4 upper rom_addr", 32'(got_rom), 32'({4'(b), a[13:0]}));
                check("R4 upper data", 32'(got_rdata), 32'(rom_model({4'(b), a[13:0]})));
            end
            rd_op(16'h0123);
            check("R1 lower ignores bank", 32'(got_rom), 32'h00123);
        end

        // R7: ignored writes
        wr_op(16'h2000, 8'h03);
        rd_op(16'h4000);
        check("R7 bank write bit4 clear", 32'(got_rom), 32'h3C000);
        wr_op(16'h3FEF, 8'h02);
        rd_op(16'h4000);
        check("R7 bank write 0x3FEF", 32'(got_rom), 32'h3C000);
        wr_op(16'h4010, 8'h0A);
        wr_op(16'h7FFF, 8'h01);
        rd_op(16'h4000);
        check("R7 upper-window write bank", 32'(got_rom), 32'h3C000);
        rd_op(16'hA000);
        check("R7 upper-window write enable", 32'(got_rdata), 32'h00);

        // R5: enable register
        wr_op(16'h0000, 8'h0A);
        wr_op(16'hA000, 8'h37);
        rd_op(16'hA000);
        check("R10 low nibble stored", 32'(got_rdata), 32'h07);
        wr_op(16'h1FEF, 8'hA5);
        rd_op(16'hA000);
        check("R5 non-key clears enable", 32'(got_rdata), 32'h00);
        wr_op(16'h0010, 8'h0A);
        rd_op(16'hA000);
        check("R7 enable write bit4 set", 32'(got_rdata), 32'h00);
        wr_op(16'h1FEF, 8'h3A);
        rd_op(16'hA000);
        check("R5 key with high bits enables", 32'(got_rdata), 32'h07);

        // R8 and R10: fill and read back through aliases
        for (int i = 0; i < 512; i++) begin
            wr_op(16'hA000 + 16'(i), {4'(i >> 4) ^ 4'h9, nib(i)});
            mdl[i] = nib(i);
        end
        for (int i = 0; i < 512; i++) begin
            int k;
            k = (i * 7) % 16;
            rd_op(16'hA000 + 16'(k * 512) + 16'(i));
            check("R8 alias read", 32'(got_rdata), 32'({4'h0, mdl[i]}));
        end

        // R9: disabled access
        wr_op(16'h0000, 8'h00);
        wr_op(16'hA005, 8'h0F);
        rd_op(16'hA005);
        check("R9 disabled read zero", 32'(got_rdata), 32'h00);
        wr_op(16'h0000, 8'h0A);
        rd_op(16'hA005);
        check("R9 disabled write dropped", 32'(got_rdata), 32'({4'h0, mdl[5]}));
        rd_op(16'hC000);
        check("R9 unmapped read zero", 32'(got_rdata), 32'h00);
        rd_op(16'h8000);
        check("R9 video area read zero", 32'(got_rdata), 32'h00);

        // R12: RAM read and write in one cycle
        op(1'b1, 1'b1, 16'hA006, 8'h0E);
        check("R12 same-cycle RAM old value", 32'(got_rdata), 32'({4'h0, mdl[6]}));
        mdl[6] = 4'hE;
        rd_op(16'hA006);
        check("R12 same-cycle RAM new value", 32'(got_rdata), 32'h0E);

        // R11 and R12: reset keeps RAM, then release plus enable in one access
        do_reset();
        rd_op(16'hA007);
        check("R11 reset disables RAM", 32'(got_rdata), 32'h00);
        rd_op(16'h4000);
        check("R11 reset bank back to 1", 32'(got_rom), 32'h04000);
        op(1'b1, 1'b1, 16'h0100, 8'h0A);
        check("R12 release read data", 32'(got_rdata), 32'(rom_model(18'h00100)));
        rd_op(16'h0000);
        check("R12 overlay released", 32'(got_rdata), 32'(rom_model(18'h00000)));
        rd_op(16'hA007);
        check("R11 RAM kept over reset", 32'(got_rdata), 32'({4'h0, mdl[7]}));

        finish_run();
    end

endmodule